// File: doc/BRIEF.md
# Aligned Transfer Chunk Planner

This block turns one block-transfer request into a series of SPI command descriptors. A request gives a start address, a byte count and a direction. The planner then issues chunks one at a time. Each chunk carries a command code, a chunk address and a chunk length. Every chunk address is naturally aligned for its command size, and the rule below keeps the number of chunks low. The block does not shift any bits onto the SPI wire. A downstream engine consumes the descriptors and does the shifting.

Requests enter over a valid/ready pair. `req_ready` is high only while the planner is idle, so a new request cannot enter while another is being split. A request stays offered until `req_ready` is seen. Chunks leave over a second valid/ready pair. While `chk_valid` is high and `chk_ready` is low, the chunk fields hold steady, and the consumer may stall for as long as it likes. Two plain one-cycle pulses report the outcome. `done` follows the last chunk handshake. `err` marks a request that was refused.

Top module: `chunk_planner`

## Requirements
- R1: After reset, `req_ready` is 1 and `chk_valid`, `done` and `err` are 0.
- R2: The chunk is a 16-bit command (length 2, read code 0) when the current address modulo 8 is 2 or 6, or when 2 bytes remain.
- R3: When R2 does not apply, the chunk is a 32-bit command (length 4, read code 2) if the address modulo 8 is 4 or if at most 6 bytes remain.
- R4: In all other cases the chunk is a burst command (read code 4). Its length is the remaining count rounded down to a multiple of 8, capped at `BURST_MAX` (240 by default).
- R5: A write uses the read code plus one: 1 for 16-bit, 3 for 32-bit and 5 for burst.
- R6: Each accepted chunk advances the address by its length and lowers the remaining count by the same amount. For example, reading 260 bytes at an address ending in 0x02 yields lengths 2, 4, 240, 8, 4 and 2, with codes 0, 2, 4, 4, 2 and 0.
- R7: While `chk_valid` is high and `chk_ready` is low, all chunk fields stay unchanged. `req_ready` is low whenever a chunk is pending.
- R8: `done` is high for exactly the one cycle after the handshake of the final chunk.
- R9: A request with an odd start address produces an `err` pulse in the cycle after acceptance and no chunks.
- R10: A read request with an odd length is refused in the same way as R9.
- R11: A write with an odd length is extended by one pad byte, so the chunks cover the length plus one. `chk_pad` is 1 only on the final chunk of such a write, marking that its last byte must be sent as zero.
- R12: A request of length zero produces a `done` pulse in the cycle after acceptance and no chunks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Planner idle and able to take a request |
| req_addr | input | ADDR_W (32) | Start byte address |
| req_len | input | LEN_W (16) | Byte count |
| req_write | input | 1 | 1 for write, 0 for read |
| chk_valid | output | 1 | Chunk descriptor present |
| chk_ready | input | 1 | Consumer takes the chunk |
| chk_cmd | output | 3 | Command code (0..5) |
| chk_addr | output | ADDR_W (32) | Chunk start address |
| chk_len | output | CLEN_W (8) | Chunk byte count |
| chk_pad | output | 1 | Final byte of this chunk is a zero pad |
| done | output | 1 | Request finished (one-cycle pulse) |
| err | output | 1 | Request refused (one-cycle pulse) |

## Verification
A wrong address register shows up at the next chunk. That chunk carries an address that breaks the running sum of earlier lengths, or an alignment that conflicts with its command size. A wrong remaining count shows up as a different length or code within one chunk, or as `done` arriving a handshake early or late. The directed cases cover each selection branch, both directions, consumer stalls, padding, refused requests and empty requests. Each case compares every chunk against a model of the rule in the bench.

// File: rtl/chunk_pkg.sv
package chunk_pkg;
  typedef enum logic [2:0] {
    CMD_RD16 = 3'd0,
    CMD_WR16 = 3'd1,
    CMD_RD32 = 3'd2,
    CMD_WR32 = 3'd3,
    CMD_RDBU = 3'd4,
    CMD_WRBU = 3'd5
  } chunk_cmd_e;
endpackage

// File: rtl/chunk_select.sv
module chunk_select
  import chunk_pkg::*;
#(
  parameter int REM_W     = 17,
  parameter int CLEN_W    = 8,
  parameter int BURST_MAX = 240
) (
  input  logic [2:0]        align,
  input  logic [REM_W-1:0]  remain,
  input  logic              write,
  output logic [2:0]        cmd,
  output logic [CLEN_W-1:0] clen
);
  chunk_cmd_e       base;
  logic [REM_W-1:0] rounded;

  always_comb begin
    rounded = {remain[REM_W-1:3], 3'b000};
    if (align == 3'd2 || align == 3'd6 || remain == REM_W'(2)) begin
      base = CMD_RD16;
      clen = CLEN_W'(2);
    end else if (align == 3'd4 || remain <= REM_W'(6)) begin
      base = CMD_RD32;
      clen = CLEN_W'(4);
    end else begin
      base = CMD_RDBU;
      clen = (rounded > REM_W'(BURST_MAX)) ? CLEN_W'(BURST_MAX) : rounded[CLEN_W-1:0];
    end
    cmd = {base[2:1], write};
  end
endmodule

// File: rtl/req_check.sv
module req_check #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  localparam int REM_W = LEN_W + 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  len,
  input  logic              write,
  output logic              reject,
  output logic              padded,
  output logic [REM_W-1:0]  total
);
  logic [ADDR_W-2:0] addr_hi_unused;

  always_comb begin
    addr_hi_unused = addr[ADDR_W-1:1];
    reject = addr[0] | (~write & len[0]);
    padded = write & len[0];
    total  = REM_W'(len) + REM_W'(padded);
  end
endmodule

// File: rtl/chunk_planner.sv
module chunk_planner #(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 16,
  parameter int BURST_MAX = 240,
  localparam int REM_W    = LEN_W + 1,
  localparam int CLEN_W   = $clog2(BURST_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              req_write,
  output logic              chk_valid,
  input  logic              chk_ready,
  output logic [2:0]        chk_cmd,
  output logic [ADDR_W-1:0] chk_addr,
  output logic [CLEN_W-1:0] chk_len,
  output logic              chk_pad,
  output logic              done,
  output logic              err
);
  logic              busy_q, wr_q, pad_q, done_q, err_q;
  logic [ADDR_W-1:0] addr_q;
  logic [REM_W-1:0]  rem_q;
  logic              reject, padded, accept, take, last;
  logic [REM_W-1:0]  total;
  logic [CLEN_W-1:0] clen;
  logic [2:0]        cmd;

  req_check #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_check (
    .addr(req_addr), .len(req_len), .write(req_write),
    .reject(reject), .padded(padded), .total(total)
  );

  chunk_select #(.REM_W(REM_W), .CLEN_W(CLEN_W), .BURST_MAX(BURST_MAX)) u_sel (
    .align(addr_q[2:0]), .remain(rem_q), .write(wr_q),
    .cmd(cmd), .clen(clen)
  );

  assign req_ready = ~busy_q;
  assign accept    = req_valid & req_ready;
  assign chk_valid = busy_q;
  assign take      = chk_valid & chk_ready;
  assign last      = (rem_q == REM_W'(clen));
  assign chk_cmd   = cmd;
  assign chk_addr  = addr_q;
  assign chk_len   = clen;
  assign chk_pad   = busy_q & pad_q & last;
  assign done      = done_q;
  assign err       = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      wr_q   <= 1'b0;
      pad_q  <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      addr_q <= '0;
      rem_q  <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (accept) begin
        if (reject) begin
          err_q <= 1'b1;
        end else if (total == '0) begin
          done_q <= 1'b1;
        end else begin
          busy_q <= 1'b1;
          addr_q <= req_addr;
          rem_q  <= total;
          wr_q   <= req_write;
          pad_q  <= padded;
        end
      end
      if (take) begin
        addr_q <= addr_q + ADDR_W'(clen);
        rem_q  <= rem_q - REM_W'(clen);
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  // R2
  size16_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid && chk_cmd[2:1] == 2'd0 |-> chk_len == CLEN_W'(2) && !chk_addr[0]);
  // R3
  size32_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid && chk_cmd[2:1] == 2'd1 |-> chk_len == CLEN_W'(4) && chk_addr[1:0] == 2'd0);
  // R4
  burst_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid && chk_cmd[2:1] == 2'd2 |->
      chk_addr[2:0] == 3'd0 && chk_len[2:0] == 3'd0 && chk_len != '0 &&
      chk_len <= CLEN_W'(BURST_MAX));
  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid && !chk_ready |=> chk_valid && $stable(chk_cmd) && $stable(chk_addr) &&
      $stable(chk_len) && $stable(chk_pad));
  // R7
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |-> !req_ready);
  // R9
  reject_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !chk_valid && !done);
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !chk_valid);
endmodule

// File: tb/chunk_planner_bench.sv
module chunk_planner_bench;
  localparam int ADDR_W = 32;
  localparam int LEN_W  = 16;
  localparam int BMAX   = 240;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [LEN_W-1:0]  req_len = '0;
  logic              req_write = 1'b0;
  logic              chk_valid;
  logic              chk_ready = 1'b0;
  logic [2:0]        chk_cmd;
  logic [ADDR_W-1:0] chk_addr;
  logic [7:0]        chk_len;
  logic              chk_pad;
  logic              done, err;

  int vectors = 0;
  int fails   = 0;
  int cycles  = 0;

  always #10 clk = ~clk;

  chunk_planner u_chunk_planner (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_len(req_len), .req_write(req_write),
    .chk_valid(chk_valid), .chk_ready(chk_ready), .chk_cmd(chk_cmd),
    .chk_addr(chk_addr), .chk_len(chk_len), .chk_pad(chk_pad),
    .done(done), .err(err)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<100000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  // Model of the selection rule from R2..R5
  task automatic model(input int unsigned a, input int unsigned rem, input bit wr,
                       output int unsigned cmd, output int unsigned len);
    int unsigned al = a % 8;
    if (al == 2 || al == 6 || rem == 2) begin cmd = 0; len = 2; end
    else if (al == 4 || rem <= 6) begin cmd = 2; len = 4; end
    else begin
      cmd = 4;
      len = ((rem / 8) * 8 > BMAX) ? BMAX : (rem / 8) * 8;
    end
    if (wr) cmd = cmd + 1;
  endtask

  task automatic do_req(input int unsigned addr, input int unsigned len, input bit wr,
                        input int stall, input string tag);
    int unsigned a = addr;
    int unsigned rem = len + ((wr && (len % 2 == 1)) ? 1 : 0);
    bit padw = wr && (len % 2 == 1);
    bit bad = (addr % 2 == 1) || (!wr && (len % 2 == 1));
    int unsigned ecmd, elen, n = 0;
    @(negedge clk);
    check(req_ready == 1'b1, {"R7 ready idle ", tag}, req_ready, 1);
    req_addr = addr; req_len = LEN_W'(len); req_write = wr; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (bad) begin
      check(err == 1'b1, {"R9/R10 err pulse ", tag}, err, 1);
      check(chk_valid == 1'b0, {"R9/R10 no chunk ", tag}, chk_valid, 0);
      @(negedge clk);
      check(err == 1'b0 && chk_valid == 1'b0 && done == 1'b0, {"R9/R10 quiet after ", tag},
            {err, chk_valid, done}, 0);
      return;
    end
    if (rem == 0) begin
      check(done == 1'b1 && chk_valid == 1'b0, {"R12 empty done ", tag}, {done, chk_valid}, 2);
      @(negedge clk);
      check(done == 1'b0, {"R12 done once ", tag}, done, 0);
      return;
    end
    while (rem > 0) begin
      model(a, rem, wr, ecmd, elen);
      if (stall > 0 && n % 2 == 0) begin
        for (int s = 0; s < stall; s++) @(negedge clk);
      end
      check(chk_valid == 1'b1, {"R6 chunk valid ", tag}, chk_valid, 1);
      check(chk_cmd == 3'(ecmd), {"R2/R3/R4/R5 code ", tag}, chk_cmd, ecmd);
      check(chk_len == 8'(elen), {"R2/R3/R4 length ", tag}, chk_len, elen);
      check(chk_addr == a, {"R6 address ", tag}, chk_addr, a);
      check(chk_pad == (padw && rem == elen), {"R11 pad flag ", tag}, chk_pad, padw && rem == elen);
      check(req_ready == 1'b0 && done == 1'b0, {"R7 busy ", tag}, {req_ready, done}, 0);
      chk_ready = 1'b1;
      @(negedge clk);
      chk_ready = 1'b0;
      a = a + elen; rem = rem - elen; n++;
    end
    check(done == 1'b1 && chk_valid == 1'b0, {"R8 done pulse ", tag}, {done, chk_valid}, 2);
    @(negedge clk);
    check(done == 1'b0 && req_ready == 1'b1, {"R8 done single ", tag}, {done, req_ready}, 1);
  endtask

  task automatic t_reset;
    check(req_ready == 1'b1, "R1 req_ready", req_ready, 1);
    check(chk_valid == 1'b0, "R1 chk_valid", chk_valid, 0);
    check(done == 1'b0 && err == 1'b0, "R1 done/err", {done, err}, 0);
  endtask

  task automatic t_example;
    // R6 fixed sequence: 2,4,240,8,4,2 with codes 0,2,4,4,2,0
    int unsigned lens[6] = '{2, 4, 240, 8, 4, 2};
    int unsigned cmds[6] = '{0, 2, 4, 4, 2, 0};
    int unsigned a = 32'h60030002;
    @(negedge clk);
    req_addr = a; req_len = 16'd260; req_write = 1'b0; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 6; i++) begin
      check(chk_valid && chk_len == 8'(lens[i]) && chk_cmd == 3'(cmds[i]) && chk_addr == a,
            "R6 example chunk", {chk_cmd, chk_len}, {3'(cmds[i]), 8'(lens[i])});
      chk_ready = 1'b1;
      @(negedge clk);
      chk_ready = 1'b0;
      a = a + lens[i];
    end
    check(done == 1'b1, "R8 example done", done, 1);
    @(negedge clk);
  endtask

  task automatic t_write_example; do_req(32'h60030002, 260, 1'b1, 0, "R5 write 260"); endtask
  task automatic t_small32;       do_req(32'h00000010, 4, 1'b0, 0, "R3 read 4"); endtask
  task automatic t_rem2;          do_req(32'h00000020, 2, 1'b0, 0, "R2 rem 2"); endtask
  task automatic t_align6;        do_req(32'h00000006, 10, 1'b0, 0, "R2 align 6"); endtask
  task automatic t_rem6;          do_req(32'h00000040, 6, 1'b1, 0, "R3 rem 6"); endtask
  task automatic t_long_stall;    do_req(32'h00001104, 1000, 1'b0, 3, "R4 R7 long stall"); endtask
  task automatic t_odd_addr;      do_req(32'h00000103, 8, 1'b1, 0, "R9 odd addr"); endtask
  task automatic t_odd_read;      do_req(32'h00000100, 7, 1'b0, 0, "R10 odd read"); endtask
  task automatic t_odd_write;     do_req(32'h00000020, 5, 1'b1, 1, "R11 write 5"); endtask
  task automatic t_odd_write_big; do_req(32'h00000200, 251, 1'b1, 0, "R11 write 251"); endtask
  task automatic t_zero;          do_req(32'h00000300, 0, 1'b0, 0, "R12 zero"); endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_example();
    t_write_example();
    t_small32();
    t_rem2();
    t_align6();
    t_rem6();
    t_long_stall();
    t_odd_addr();
    t_odd_read();
    t_odd_write();
    t_odd_write_big();
    t_zero();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule